// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs the external bus cycles of a small 8-bit processor whose 16-bit address leaves the core on two paths. The upper address byte has its own dedicated lines. The lower address byte shares one byte lane with the data. The core places one request at a time: a cycle kind, an address and, for writes, a data byte. The sequencer then steps through clock states (T-states) and drives the address latch strobe, the active-low read and write strobes, the memory/IO select and the two status bits. It also drives the upper address byte and the shared lane.

The shared lane carries the low address byte in the first T-state. An external latch captures it on the falling edge of the latch strobe. After that the lane carries data. A slow device can hold the bus-ready input low to stretch the cycle by whole clock periods. When the last T-state ends, the block gives a one-cycle done pulse. For a read, the captured byte is presented with that pulse.

Top module: `mbus_seq`

## Requirements
- R1: `req_type` encodes the cycle kind: 0 opcode fetch, 1 memory read, 2 memory write, 3 IO read, 4 IO write, 5 halt. The status pair {s1,s0} is 11 for a fetch, 10 for a memory or IO read, 01 for a memory or IO write, and 00 for a halt. When idle, {s1,s0} is also 00.
- R2: `io_m` is 1 for the whole of an IO read or IO write cycle. It is 0 for memory, fetch and halt cycles and while idle.
- R3: `ale` is high for exactly one clock, in T1 of every cycle except a halt. During that clock the lane is enabled and carries the low address byte.
- R4: After T1, a write drives the write byte on the lane through T2, any wait states and T3. A read or fetch releases the lane (`lane_oe` = 0) after T1. The lane is also released in T4.
- R5: `rd_n` is low in T2, in wait states and in T3 of fetch and read cycles. `wr_n` is low in the same states of write cycles. The two strobes are never low together.
- R6: `bus_rdy` is sampled at the end of T2 and at the end of each wait state. While it is low, wait states are inserted, and each one repeats the outputs of T2.
- R7: `addr_hi` carries the upper address byte, unchanged, in every T-state of a cycle. It is 0 while idle.
- R8: A fetch lasts 4 T-states plus waits. Every other read or write lasts 3 T-states plus waits. `rsp_done` is high for exactly one clock, right after the last T-state. For a fetch or read, `rsp_data` holds the lane value sampled at the clock edge that ends T3.
- R9: A halt cycle lasts exactly 3 T-states. During it `ale` stays low, both strobes stay high, the lane stays released and `bus_rdy` has no effect.
- R10: `req_type` codes 6 and 7 are run as halt cycles.
- R11: Reset returns the block to idle. In idle, `req_ready` = 1, `ale` = 0, both strobes are high, the lane is released and `rsp_done` = 0. A request is accepted only while `req_ready` is high. `req_valid` during a running cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_type | input | 3 | Cycle kind (see R1) |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, able to take a request |
| bus_rdy | input | 1 | Device ready; low inserts wait states |
| addr_hi | output | 8 | Upper address byte |
| lane_out | output | 8 | Shared lane, driven value |
| lane_oe | output | 1 | Shared lane output enable |
| lane_in | input | 8 | Shared lane, received value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| io_m | output | 1 | High for IO, low for memory |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_data | output | 8 | Read byte, valid with rsp_done |

## Verification
The bound properties check on every clock that:
- the two strobes are never low together;
- the latch strobe is a single-clock pulse that only ever appears with the lane driven;
- the memory/IO select does not change inside a cycle;
- the done pulse is one clock long;
- a halt never drives the lane or a strobe.

Only the bench's scenarios can show the cycle lengths, the number of wait states that follow a given ready pattern, the captured read bytes, and that a request arriving mid-cycle is dropped. The bench's behavioural model is compared with every output on every clock across fetch, read, write, IO, halt and reserved-code cycles, with and without waits.

// File: rtl/mbus_seq.sv
module mbus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_type,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          bus_rdy,
  output logic [AW-DW-1:0] addr_hi,
  output logic [DW-1:0] lane_out,
  output logic          lane_oe,
  input  logic [DW-1:0] lane_in,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          io_m,
  output logic          s1,
  output logic          s0,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_data
);
  typedef enum logic [2:0] {ST_IDLE, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4} tstate_t;

  tstate_t st, st_nxt;
  logic [2:0]    kind;
  logic [AW-1:0] adr;
  logic [DW-1:0] wd;

  wire is_halt  = kind >= 3'd5;
  wire is_fetch = kind == 3'd0;
  wire is_wr    = (kind == 3'd2) || (kind == 3'd4);
  wire is_io    = (kind == 3'd3) || (kind == 3'd4);
  wire is_rd    = !is_halt && !is_wr;
  wire busy     = st != ST_IDLE;
  wire strobe   = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);

  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: if (req_valid) st_nxt = ST_T1;
      ST_T1:   st_nxt = ST_T2;
      ST_T2,
      ST_TW:   st_nxt = (is_halt || bus_rdy) ? ST_T3 : ST_TW;
      ST_T3:   st_nxt = is_fetch ? ST_T4 : ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      kind     <= 3'd5;
      adr      <= '0;
      wd       <= '0;
      rsp_done <= 1'b0;
      rsp_data <= '0;
    end else begin
      st       <= st_nxt;
      rsp_done <= (st == ST_T4) || (st == ST_T3 && !is_fetch);
      if (st == ST_IDLE && req_valid) begin
        kind <= req_type;
        adr  <= req_addr;
        wd   <= req_wdata;
      end
      if (st == ST_T3 && is_rd) rsp_data <= lane_in;
    end
  end

  assign req_ready = !busy;
  assign ale       = (st == ST_T1) && !is_halt;
  assign lane_oe   = !is_halt && ((st == ST_T1) || (is_wr && strobe));
  assign lane_out  = !lane_oe ? '0 : (st == ST_T1) ? adr[DW-1:0] : wd;
  assign addr_hi   = busy ? adr[AW-1:DW] : '0;
  assign rd_n      = !(is_rd && strobe);
  assign wr_n      = !(is_wr && !is_halt && strobe);
  assign io_m      = busy && is_io;
  assign s1        = busy && is_rd;
  assign s0        = busy && (is_fetch || is_wr);
endmodule

module mbus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic bus_rdy,
  input logic lane_oe,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic io_m,
  input logic s1,
  input logic s0,
  input logic rsp_done
);
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  assert_ale_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_ale_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (lane_oe && !req_ready));

  assert_iom_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !req_ready && !$past(req_ready)) |-> $stable(io_m));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> req_ready);

  assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !s1 && !s0) |-> (rd_n && wr_n && !lane_oe && !ale && !io_m));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (rd_n && wr_n && !ale && !lane_oe));
endmodule

bind mbus_seq mbus_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .bus_rdy(bus_rdy),
  .lane_oe(lane_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
  .s1(s1), .s0(s0), .rsp_done(rsp_done)
);

// File: tb/mbus_seq_tb.sv
module mbus_seq_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [2:0] req_type = 0;
  logic [15:0] req_addr = 0;
  logic [7:0] req_wdata = 0;
  logic bus_rdy = 1;
  logic [7:0] lane_in;
  logic req_ready, lane_oe, ale, rd_n, wr_n, io_m, s1, s0, rsp_done;
  logic [7:0] addr_hi, lane_out, rsp_data;

  int checks = 0, failures = 0;
  logic [7:0] mem_byte = 8'h00;
  int wait_left = 0;
  bit hold_low = 0;
  bit model_on = 0;

  always #5 clk = ~clk;

  assign lane_in = rd_n ? 8'h00 : mem_byte;

  mbus_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .bus_rdy(bus_rdy), .addr_hi(addr_hi), .lane_out(lane_out), .lane_oe(lane_oe),
    .lane_in(lane_in), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m),
    .s1(s1), .s0(s0), .rsp_done(rsp_done), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1..4 are T1..T4, 9 wait state
  int m_ph = 0, m_kind = 5, m_tick = 0;
  logic [15:0] m_addr = 0;
  logic [7:0]  m_wd = 0, m_rdata = 0;
  bit m_done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_rdata = 0;
    end else begin
      bit halt;
      bit last;
      halt = (m_kind >= 5);
      last = (m_ph == 4) || (m_ph == 3 && m_kind != 0);
      if (m_ph == 3 && !halt && m_kind != 2 && m_kind != 4) m_rdata = lane_in;
      m_done = last;
      case (m_ph)
        0: if (req_valid) begin
             m_ph = 1; m_kind = req_type; m_addr = req_addr; m_wd = req_wdata;
           end
        1: m_ph = 2;
        2, 9: m_ph = (halt || bus_rdy) ? 3 : 9;
        3: m_ph = (m_kind == 0) ? 4 : 0;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      bit busy, halt, wr, io, rdk, strobe, e_oe;
      busy = (m_ph != 0);
      halt = (m_kind >= 5);
      wr = (m_kind == 2 || m_kind == 4);
      io = (m_kind == 3 || m_kind == 4);
      rdk = !halt && !wr;
      strobe = (m_ph == 2 || m_ph == 3 || m_ph == 9);
      e_oe = busy && !halt && (m_ph == 1 || (wr && strobe));
      chk(req_ready == !busy, "R11 req_ready", req_ready, !busy);
      chk(s1 == (busy && rdk), "R1 s1", s1, busy && rdk);
      chk(s0 == (busy && (m_kind == 0 || wr)), "R1 s0", s0, busy && (m_kind == 0 || wr));
      chk(io_m == (busy && io), "R2 io_m", io_m, busy && io);
      chk(ale == (m_ph == 1 && !halt), "R3 ale", ale, m_ph == 1 && !halt);
      chk(lane_oe == e_oe, "R4 lane_oe", lane_oe, e_oe);
      if (e_oe && m_ph == 1) chk(lane_out == m_addr[7:0], "R3 lane addr", lane_out, m_addr[7:0]);
      if (e_oe && m_ph != 1) chk(lane_out == m_wd, "R4 lane data", lane_out, m_wd);
      chk(rd_n == !(busy && rdk && strobe), "R5 rd_n", rd_n, !(busy && rdk && strobe));
      chk(wr_n == !(busy && wr && !halt && strobe), "R5 wr_n", wr_n, !(busy && wr && !halt && strobe));
      chk(addr_hi == (busy ? m_addr[15:8] : 8'h00), "R7 addr_hi", addr_hi, busy ? m_addr[15:8] : 8'h00);
      chk(rsp_done == m_done, "R8 rsp_done", rsp_done, m_done);
      if (m_done) chk(rsp_data == m_rdata, "R8 rsp_data", rsp_data, m_rdata);
    end
  end

  // Ready responder
  always @(negedge clk) begin
    if (hold_low) bus_rdy <= 1'b0;
    else if ((!rd_n || !wr_n) && wait_left > 0) begin
      bus_rdy <= 1'b0;
      wait_left--;
    end else bus_rdy <= 1'b1;
  end

  task automatic run_cycle(input logic [2:0] kind, input logic [15:0] a, input logic [7:0] d,
                           input int waits, input bit poke_busy, input int tag_len);
    int len;
    bit rd;
    len = 0;
    while (!req_ready) @(negedge clk);
    mem_byte = a[7:0] ^ 8'hA5;
    wait_left = waits;
    req_valid = 1; req_type = kind; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_done) begin
      len++;
      if (poke_busy && len == 2) begin
        req_valid = 1; req_type = 3'd1; req_addr = 16'hFFFF;
      end else req_valid = 0;
      @(negedge clk);
    end
    req_valid = 0;
    chk(len == tag_len, "R8 cycle length", len, tag_len);
    rd = (kind == 0 || kind == 1 || kind == 3);
    if (rd) chk(rsp_data == (a[7:0] ^ 8'hA5), "R8 read byte", rsp_data, a[7:0] ^ 8'hA5);
    @(negedge clk);
    if (poke_busy) chk(req_ready == 1, "R11 mid-cycle request ignored", req_ready, 1);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && rd_n && wr_n && !ale && !lane_oe && !rsp_done, "R11 reset state",
        {req_ready, rd_n, wr_n, ale, lane_oe, rsp_done}, 6'b111000);
    rst_n = 1;
    model_on = 1;
    @(negedge clk);
    run_cycle(3'd0, 16'h1234, 8'h00, 0, 0, 4);   // R1 fetch
    run_cycle(3'd1, 16'h2F81, 8'h00, 2, 0, 5);   // R6 read with waits
    run_cycle(3'd2, 16'h8001, 8'h3C, 1, 0, 4);   // R4 write with wait
    run_cycle(3'd3, 16'h00C7, 8'h00, 0, 0, 3);   // R2 IO read
    run_cycle(3'd4, 16'h0055, 8'h9E, 3, 0, 6);   // R2 IO write
    run_cycle(3'd0, 16'hFFFE, 8'h00, 2, 1, 6);   // R11 poke while busy
    hold_low = 1;
    run_cycle(3'd5, 16'hABCD, 8'h11, 0, 0, 3);   // R9 halt ignores bus_rdy
    run_cycle(3'd7, 16'h4321, 8'h22, 0, 0, 3);   // R10 reserved code
    hold_low = 0;
    run_cycle(3'd6, 16'h0F0F, 8'h33, 0, 0, 3);   // R10 reserved code
    run_cycle(3'd1, 16'h7777, 8'h00, 0, 0, 3);
    repeat (2) @(negedge clk);
    chk(req_ready == 1 && rsp_done == 0, "R11 back to idle", req_ready, 1);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule